// File: doc/BRIEF.md
# Card Socket Status Input Monitor

This block watches the eight status pins of a removable-card socket. Each raw, asynchronous pin passes through a synchronizer chain. The settled level can be read at any time. Per-pin transition detectors set sticky change flags, and each flag has its own interrupt enable. A single registered interrupt request is raised whenever any enabled flag is set. Software clears a flag by writing a 1 to it.

On top of the generic edge logic, the block interprets the pins as socket signals:

| Pin | Signal |
|---|---|
| 0, 1 | Voltage-sense pair |
| 2 | Write protect |
| 3 | Card detect, second pin |
| 4 | Card detect, first pin |
| 5 | Battery detect, second pin |
| 6 | Battery detect, first pin |
| 7 | Ready/busy (memory mode) or interrupt request (I/O mode) |

The block reports card presence, a three-level battery health code and mode-dependent meanings of pins 6 and 7. Only pin 7 has a selectable edge sensitivity.

Software reaches the block through a simple word-wide register port. Writes take effect on the rising edge when `bus_wr` is high. Reads are combinational from `bus_addr`. The register map is:

| Address | Register | Access |
|---|---|---|
| 0 | Synchronized levels | Read only |
| 1 | Change flags | Write 1 to clear |
| 2 | Interrupt enables | Read/write |
| 3 | Control | Read/write |
| 4 | Decoded status | Read only |

The control register holds the pin-7 edge mode in bits [1:0] and the I/O-mode select in bit 2 (1 = I/O, 0 = memory).

Top module: `card_status_port`

## Requirements
- R1: A level change on any pin is visible in the level register (address 0, bit i = pin i) after two rising clock edges.
- R2: For pins 0 to 6, a high-to-low change sets change flag i (address 1) on the third rising edge after the pin changes. A low-to-high change sets no flag.
- R3: Pin 7 detects edges according to control bits [1:0]: 00 detects falling edges only, 01 detects rising edges only, and 10 or 11 detects both edges.
- R4: Change flags are sticky. Writing 1 to a flag bit at address 1 clears it. Writing 0 leaves the flag unchanged.
- R5: When a new edge and a clear of the same flag land on the same clock edge, the flag ends up set.
- R6: `irq_o` goes high one clock after any flag is set together with its enable bit (address 2, bit i). It goes low one clock after no such pair remains.
- R7: After reset, the levels read all ones, the flags, enables and control register read zero, and `irq_o` is low.
- R8: Status bit 0 (card present) is 1 only when both pin 3 and pin 4 are low.
- R9: In memory mode, status bits [2:1] give the battery health: 00 (good) when pins 5 and 6 are both low, 01 (warning) when pin 5 is high and pin 6 is low, and 10 (failed) whenever pin 6 is high. In I/O mode the field reads 00.
- R10: Status bit 4 (busy) is 1 in memory mode when pin 7 is low. In I/O mode, bit 5 (status change) is 1 when pin 6 is low and bit 6 (interrupt request) is 1 when pin 7 is low. Each of these bits is 0 in the other mode.
- R11: Status bit 3 gives the pin 2 level (1 = write protected). Status bits [8:7] give pins 1 and 0, in that order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_i | input | 8 | Raw socket status pins, asynchronous |
| bus_addr | input | 3 | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for `bus_addr` |
| irq_o | output | 1 | Combined registered interrupt request |

## Verification
The hardest case to reach is the collision between a software clear and a fresh edge on the same flag. The edge pulse exists for exactly one cycle, two clock edges after the pin moves. The stimulus sets the flag first, lets the pin return high, and then drops the pin again. After counting exactly two clock edges, it drives the clear so that the write lands on the same edge as the new detection. The pin-7 mode cases are reached the same way: control register writes are interleaved with pin toggles, and each toggle direction is checked in each mode.

// File: rtl/csp_pkg.sv
package csp_pkg;

   localparam int unsigned REG_LEVEL  = 0;
   localparam int unsigned REG_FLAGS  = 1;
   localparam int unsigned REG_ENABLE = 2;
   localparam int unsigned REG_CTRL   = 3;
   localparam int unsigned REG_STATUS = 4;

   localparam int unsigned PIN_VS0  = 0;
   localparam int unsigned PIN_VS1  = 1;
   localparam int unsigned PIN_WP   = 2;
   localparam int unsigned PIN_CD2  = 3;
   localparam int unsigned PIN_CD1  = 4;
   localparam int unsigned PIN_BAT2 = 5;
   localparam int unsigned PIN_BAT1 = 6;
   localparam int unsigned PIN_RDY  = 7;

   typedef enum logic [1:0] {
      EDGE_FALL     = 2'b00,
      EDGE_RISE     = 2'b01,
      EDGE_BOTH     = 2'b10,
      EDGE_BOTH_ALT = 2'b11
   } edge_mode_e;

   typedef enum logic [1:0] {
      BATT_GOOD = 2'b00,
      BATT_WARN = 2'b01,
      BATT_FAIL = 2'b10
   } batt_e;

   typedef struct packed {
      logic [1:0] vsense;
      logic       io_irq;
      logic       io_change;
      logic       busy;
      logic       wprot;
      batt_e      batt;
      logic       present;
   } sock_status_t;

   localparam int unsigned STATUS_W = $bits(sock_status_t);

endpackage

// File: rtl/csp_sync.sv
module csp_sync #(
   parameter int unsigned WIDTH     = 8,
   parameter int unsigned STAGES    = 2,
   parameter logic        RST_LEVEL = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] raw_i,
   output logic [WIDTH-1:0] cur_o,
   output logic [WIDTH-1:0] prev_o
);

   localparam int unsigned DEPTH = STAGES + 1;

   if (STAGES < 2) begin : g_bad_stages
      $error("csp_sync: STAGES must be at least 2");
   end

   logic [WIDTH-1:0] chain [DEPTH];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int k = 0; k < DEPTH; k++) chain[k] <= {WIDTH{RST_LEVEL}};
      end else begin
         chain[0] <= raw_i;
         for (int k = 1; k < DEPTH; k++) chain[k] <= chain[k-1];
      end
   end

   assign cur_o  = chain[STAGES-1];
   assign prev_o = chain[STAGES];

endmodule

// File: rtl/csp_edge.sv
module csp_edge
   import csp_pkg::*;
#(
   parameter int unsigned WIDTH   = 8,
   parameter int unsigned EXT_BIT = 7
) (
   input  logic [WIDTH-1:0] cur_i,
   input  logic [WIDTH-1:0] prev_i,
   input  logic [1:0]       ext_mode_i,
   output logic [WIDTH-1:0] pulse_o
);

   if (EXT_BIT >= WIDTH) begin : g_bad_ext
      $error("csp_edge: EXT_BIT out of range");
   end

   function automatic logic ext_hit(input logic [1:0] mode, input logic cur, input logic prev);
      logic fall, rise;
      fall = prev & ~cur;
      rise = ~prev & cur;
      case (edge_mode_e'(mode))
         EDGE_FALL: return fall;
         EDGE_RISE: return rise;
         default:   return fall | rise;
      endcase
   endfunction

   for (genvar i = 0; i < WIDTH; i++) begin : g_bit
      if (i == EXT_BIT) begin : g_ext
         assign pulse_o[i] = ext_hit(ext_mode_i, cur_i[i], prev_i[i]);
      end else begin : g_fall
         assign pulse_o[i] = prev_i[i] & ~cur_i[i];
      end
   end

endmodule

// File: rtl/csp_flags.sv
module csp_flags #(
   parameter int unsigned WIDTH = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] set_i,
   input  logic [WIDTH-1:0] clr_i,
   output logic [WIDTH-1:0] flags_o
);

   logic [WIDTH-1:0] flags_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flags_q <= '0;
      else        flags_q <= (flags_q & ~clr_i) | set_i;
   end

   assign flags_o = flags_q;

   for (genvar i = 0; i < WIDTH; i++) begin : g_chk
      p_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
         (flags_q[i] && !clr_i[i]) |=> flags_q[i])
         else $error("flag %0d dropped without clear", i);
      p_set_wins_r5: assert property (@(posedge clk) disable iff (!rst_n)
         (set_i[i] && clr_i[i]) |=> flags_q[i])
         else $error("clear beat a new edge on flag %0d", i);
      p_clear_works_r4: assert property (@(posedge clk) disable iff (!rst_n)
         (clr_i[i] && !set_i[i]) |=> !flags_q[i])
         else $error("flag %0d survived a clear", i);
   end

endmodule

// File: rtl/csp_decode.sv
module csp_decode
   import csp_pkg::*;
(
   input  logic [7:0]   lvl_i,
   input  logic         io_mode_i,
   output sock_status_t status_o
);

   batt_e batt_mem;

   always_comb begin
      if (lvl_i[PIN_BAT1])      batt_mem = BATT_FAIL;
      else if (lvl_i[PIN_BAT2]) batt_mem = BATT_WARN;
      else                      batt_mem = BATT_GOOD;
   end

   always_comb begin
      status_o.present   = ~lvl_i[PIN_CD1] & ~lvl_i[PIN_CD2];
      status_o.batt      = io_mode_i ? BATT_GOOD : batt_mem;
      status_o.wprot     = lvl_i[PIN_WP];
      status_o.busy      = ~io_mode_i & ~lvl_i[PIN_RDY];
      status_o.io_change =  io_mode_i & ~lvl_i[PIN_BAT1];
      status_o.io_irq    =  io_mode_i & ~lvl_i[PIN_RDY];
      status_o.vsense    = {lvl_i[PIN_VS1], lvl_i[PIN_VS0]};
   end

endmodule

// File: rtl/card_status_port.sv
module card_status_port
   import csp_pkg::*;
#(
   parameter int unsigned N_PINS      = 8,
   parameter int unsigned ADDR_W      = 3,
   parameter int unsigned DATA_W      = 16,
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned EXT_BIT     = 7
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [N_PINS-1:0] pin_i,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_wr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              irq_o
);

   localparam int unsigned CTRL_W = 3;
   localparam int unsigned IO_BIT = 2;

   if (N_PINS != 8) begin : g_bad_pins
      $error("card_status_port: the socket decode needs exactly 8 pins");
   end
   if (DATA_W < STATUS_W || DATA_W < N_PINS) begin : g_bad_data
      $error("card_status_port: DATA_W too narrow for the status word");
   end
   if ((1 << ADDR_W) <= REG_STATUS) begin : g_bad_addr
      $error("card_status_port: ADDR_W cannot reach every register");
   end

   logic [N_PINS-1:0] lvl, lvl_prev, pulse, flags, clr, en_q;
   logic [CTRL_W-1:0] ctrl_q;
   logic              irq_q;
   sock_status_t      status;

   wire wr_flags = bus_wr && (bus_addr == ADDR_W'(REG_FLAGS));
   wire wr_en    = bus_wr && (bus_addr == ADDR_W'(REG_ENABLE));
   wire wr_ctrl  = bus_wr && (bus_addr == ADDR_W'(REG_CTRL));

   csp_sync #(.WIDTH(N_PINS), .STAGES(SYNC_STAGES), .RST_LEVEL(1'b1)) u_sync (
      .clk    (clk),
      .rst_n  (rst_n),
      .raw_i  (pin_i),
      .cur_o  (lvl),
      .prev_o (lvl_prev)
   );

   csp_edge #(.WIDTH(N_PINS), .EXT_BIT(EXT_BIT)) u_edge (
      .cur_i      (lvl),
      .prev_i     (lvl_prev),
      .ext_mode_i (ctrl_q[1:0]),
      .pulse_o    (pulse)
   );

   assign clr = wr_flags ? bus_wdata[N_PINS-1:0] : '0;

   csp_flags #(.WIDTH(N_PINS)) u_flags (
      .clk     (clk),
      .rst_n   (rst_n),
      .set_i   (pulse),
      .clr_i   (clr),
      .flags_o (flags)
   );

   csp_decode u_dec (
      .lvl_i     (lvl),
      .io_mode_i (ctrl_q[IO_BIT]),
      .status_o  (status)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q   <= '0;
         ctrl_q <= '0;
         irq_q  <= 1'b0;
      end else begin
         if (wr_en)   en_q   <= bus_wdata[N_PINS-1:0];
         if (wr_ctrl) ctrl_q <= bus_wdata[CTRL_W-1:0];
         irq_q <= |(flags & en_q);
      end
   end

   assign irq_o = irq_q;

   always_comb begin
      bus_rdata = '0;
      case (bus_addr)
         ADDR_W'(REG_LEVEL):  bus_rdata[N_PINS-1:0]   = lvl;
         ADDR_W'(REG_FLAGS):  bus_rdata[N_PINS-1:0]   = flags;
         ADDR_W'(REG_ENABLE): bus_rdata[N_PINS-1:0]   = en_q;
         ADDR_W'(REG_CTRL):   bus_rdata[CTRL_W-1:0]   = ctrl_q;
         ADDR_W'(REG_STATUS): bus_rdata[STATUS_W-1:0] = status;
         default:             bus_rdata = '0;
      endcase
   end

   p_irq_rise_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (|(flags & en_q)) |=> irq_o)
      else $error("irq missing after enabled flag");
   p_irq_fall_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !(|(flags & en_q)) |=> !irq_o)
      else $error("irq high without enabled flag");
   p_present_r8: assert property (@(posedge clk) disable iff (!rst_n)
      status.present |-> (!lvl[PIN_CD1] && !lvl[PIN_CD2]))
      else $error("card present with a detect pin high");
   p_batt_legal_r9: assert property (@(posedge clk) disable iff (!rst_n)
      status.batt != 2'b11)
      else $error("illegal battery code");
   p_mode_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !(status.busy && (status.io_irq || status.io_change)))
      else $error("memory and I/O decodes active together");

endmodule

// File: tb/card_status_port_bench.sv
module card_status_port_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  pins = 8'hFF;
   logic [2:0]  bus_addr = '0;
   logic        bus_wr = 1'b0;
   logic [15:0] bus_wdata = '0;
   logic [15:0] bus_rdata;
   logic        irq_o;

   int n_chk = 0;
   int n_bad = 0;

   always #10 clk = ~clk;

   card_status_port u_card_status_port (
      .clk       (clk),
      .rst_n     (rst_n),
      .pin_i     (pins),
      .bus_addr  (bus_addr),
      .bus_wr    (bus_wr),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata),
      .irq_o     (irq_o)
   );

   task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic rd(input int a, output logic [15:0] d);
      bus_addr = a[2:0];
      #1;
      d = bus_rdata;
   endtask

   task automatic wr(input int a, input logic [15:0] d);
      bus_addr  = a[2:0];
      bus_wdata = d;
      bus_wr    = 1'b1;
      @(negedge clk);
      bus_wr    = 1'b0;
   endtask

   task automatic expect_reg(input string req, input int a, input logic [15:0] exp);
      logic [15:0] d;
      rd(a, d);
      check(req, d, exp);
   endtask

   task automatic t_reset;
      tick(3);
      expect_reg("R7 levels", 0, 16'h00FF);
      expect_reg("R7 flags", 1, 16'h0000);
      expect_reg("R7 enables", 2, 16'h0000);
      expect_reg("R7 ctrl", 3, 16'h0000);
      check("R7 irq", {15'b0, irq_o}, 16'h0000);
      expect_reg("R9 idle status fail", 4, 16'h018C);
   endtask

   task automatic t_fall;
      pins = 8'hFE;
      tick(2);
      expect_reg("R1 level after two edges", 0, 16'h00FE);
      expect_reg("R2 flag not early", 1, 16'h0000);
      tick(1);
      expect_reg("R2 flag on third edge", 1, 16'h0001);
   endtask

   task automatic t_rise_ignored;
      pins = 8'hDE;
      tick(3);
      expect_reg("R2 second flag", 1, 16'h0021);
      wr(1, 16'h00FF);
      expect_reg("R4 clear all", 1, 16'h0000);
      pins = 8'hFE;
      tick(4);
      expect_reg("R2 rising ignored", 1, 16'h0000);
   endtask

   task automatic t_w1c;
      pins = 8'hFC;
      tick(3);
      expect_reg("R4 set", 1, 16'h0002);
      wr(1, 16'h0000);
      expect_reg("R4 write zero kept", 1, 16'h0002);
      wr(1, 16'h00FD);
      expect_reg("R4 other bits kept", 1, 16'h0002);
      wr(1, 16'h0002);
      expect_reg("R4 cleared", 1, 16'h0000);
   endtask

   task automatic t_irq;
      pins = 8'hF8;
      tick(4);
      expect_reg("R6 flag present", 1, 16'h0004);
      check("R6 masked irq", {15'b0, irq_o}, 16'h0000);
      wr(2, 16'h0004);
      expect_reg("R6 enable readback", 2, 16'h0004);
      check("R6 irq not yet", {15'b0, irq_o}, 16'h0000);
      tick(1);
      check("R6 irq raised", {15'b0, irq_o}, 16'h0001);
      wr(1, 16'h0004);
      check("R6 irq still one cycle", {15'b0, irq_o}, 16'h0001);
      tick(1);
      check("R6 irq dropped", {15'b0, irq_o}, 16'h0000);
      wr(2, 16'h0000);
   endtask

   task automatic t_ext;
      pins = 8'h78;
      tick(3);
      expect_reg("R3 fall mode falling", 1, 16'h0080);
      wr(1, 16'h0080);
      pins = 8'hF8;
      tick(4);
      expect_reg("R3 fall mode rising", 1, 16'h0000);
      wr(3, 16'h0001);
      pins = 8'h78;
      tick(4);
      expect_reg("R3 rise mode falling", 1, 16'h0000);
      pins = 8'hF8;
      tick(3);
      expect_reg("R3 rise mode rising", 1, 16'h0080);
      wr(1, 16'h0080);
      wr(3, 16'h0002);
      expect_reg("R3 ctrl readback", 3, 16'h0002);
      pins = 8'h78;
      tick(3);
      expect_reg("R3 both mode falling", 1, 16'h0080);
      wr(1, 16'h0080);
      pins = 8'hF8;
      tick(3);
      expect_reg("R3 both mode rising", 1, 16'h0080);
      wr(1, 16'h0080);
      wr(3, 16'h0003);
      pins = 8'h78;
      tick(3);
      expect_reg("R3 mode 11 falling", 1, 16'h0080);
      wr(1, 16'h0080);
      pins = 8'hF8;
      tick(3);
      expect_reg("R3 mode 11 rising", 1, 16'h0080);
      wr(1, 16'h0080);
      wr(3, 16'h0000);
   endtask

   task automatic t_collide;
      pins = 8'hF9;
      tick(3);
      expect_reg("R2 bit0 rising ignored", 1, 16'h0000);
      pins = 8'hF8;
      tick(3);
      expect_reg("R5 flag preset", 1, 16'h0001);
      pins = 8'hF9;
      tick(3);
      pins = 8'hF8;
      tick(2);
      bus_addr  = 3'd1;
      bus_wdata = 16'h0001;
      bus_wr    = 1'b1;
      @(negedge clk);
      bus_wr    = 1'b0;
      expect_reg("R5 edge beats clear", 1, 16'h0001);
      wr(1, 16'h0001);
      expect_reg("R5 later clear", 1, 16'h0000);
   endtask

   task automatic t_decode;
      wr(3, 16'h0000);
      pins = 8'b1000_0001;
      tick(2);
      expect_reg("R8 R9 R11 present good", 4, 16'h0081);
      pins = 8'b0011_0110;
      tick(2);
      expect_reg("R8 R9 R10 R11 warn busy", 4, 16'h011A);
      pins = 8'b0100_1000;
      tick(2);
      expect_reg("R8 R9 R10 fail busy", 4, 16'h0014);
      wr(3, 16'h0004);
      pins = 8'b0010_0000;
      tick(2);
      expect_reg("R10 R9 io change irq", 4, 16'h0061);
      pins = 8'b1100_0000;
      tick(2);
      expect_reg("R10 io idle", 4, 16'h0001);
   endtask

   initial begin
      tick(3);
      rst_n = 1'b1;
      t_reset();
      t_fall();
      t_rise_ignored();
      t_w1c();
      t_irq();
      t_ext();
      t_collide();
      t_decode();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

endmodule